// File: doc/BRIEF.md
# Edge-aligned PWM timer channel

This block is one channel of a general-purpose timer. An up-counter runs from zero to a reload limit, then wraps. On each clock the count is compared with a compare value, and the result drives a registered reference waveform. The reference does not simply follow the comparison. It is written only when the comparison result flips, or when the mode field leaves the frozen setting for one of the two PWM settings. Because of this, a level forced by the external clear input stays in place until the next period begins.

The reload and compare inputs are preload values. They are copied into the working registers at the counter wrap, so a period in progress is never cut short. A compare-match pulse marks the cycle in which the count equals the compare value. A sticky flag records the match until software clears it. Two settings are not implemented: counting down, and the center-aligned values of the alignment field. Either of them, or a low enable, freezes the counter and the reference.

Top module: `pwm_edge_channel`

## Requirements
- R1: While running, the counter steps 0,1,…,ARR and then returns to 0. One period therefore lasts ARR+1 clocks.
- R2: `arr_in` and `cmp_in` are copied into the working registers only in the cycle where the counter wraps. The first running cycle after reset counts as such a wrap.
- R3: Mode 3'b110 (PWM 1) drives `ref_out` high one clock after a count below the working compare value, and low otherwise.
- R4: Mode 3'b111 (PWM 2) drives `ref_out` to the inverse of the PWM 1 level.
- R5: In PWM 1, a compare value of 0 keeps `ref_out` low for the whole period. A compare value above ARR keeps it high.
- R6: Mode 3'b000 (frozen) and every other code except 3'b110 and 3'b111 leave `ref_out` unchanged. The counter keeps running in these modes.
- R7: A change from 3'b000 to a PWM mode sets `ref_out` to the current comparison level on the next clock, even if the comparison has not changed.
- R8: In a PWM mode, `ext_clr` high drives `ref_out` low on the next clock. `ref_out` then stays low until the comparison result changes or the next period starts at count 0, whichever comes first.
- R9: `match_pulse` is high for the cycle in which the count equals the working compare value. `match_flag` goes high one clock later and stays high until `flag_clr` is sampled high. A new match wins over a clear in the same cycle. After reset `ref_out`, `match_pulse` and `match_flag` are 0.
- R10: With `en` low, the counter and `ref_out` hold their values and `match_pulse` is 0.
- R11: With `dir`=1 (down) or `align`≠2'b00 (center-aligned), the block behaves exactly as with `en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable |
| dir | input | 1 | Direction, 0 = up |
| align | input | 2 | Alignment select, 2'b00 = edge-aligned |
| mode | input | 3 | Output-compare mode |
| arr_in | input | W | Reload preload value |
| cmp_in | input | W | Compare preload value |
| ext_clr | input | 1 | External clear of the reference |
| flag_clr | input | 1 | Write-one-to-clear of the match flag |
| ref_out | output | 1 | Reference PWM waveform |
| match_pulse | output | 1 | Count equals compare this cycle |
| match_flag | output | 1 | Sticky compare-match flag |

## Verification
The bench builds the channel with W=4. With that width, compare values above the reload limit (such as 12 against a limit of 8) and a limit at the top of the range are easy to reach. A short limit also keeps periods to a handful of clocks, so many wraps occur, and with them preload updates and clear releases, within a few hundred cycles. A behavioural model runs beside the design and is compared with all three outputs on every clock.

// File: rtl/pwm_edge_channel.sv
module pwm_edge_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         dir,
  input  logic [1:0]   align,
  input  logic [2:0]   mode,
  input  logic [W-1:0] arr_in,
  input  logic [W-1:0] cmp_in,
  input  logic         ext_clr,
  input  logic         flag_clr,
  output logic         ref_out,
  output logic         match_pulse,
  output logic         match_flag
);

  localparam logic [2:0] FROZEN = 3'b000;

  logic [W-1:0] cnt, arr_act, cmp_act;
  logic [2:0]   mode_q;
  logic         res_q, ref_q, hold_q, flag_q;

  wire run  = en & ~dir & (align == 2'b00);
  wire pwm  = (mode == 3'b110) | (mode == 3'b111);
  wire res  = cnt < cmp_act;
  wire lvl  = mode[0] ? ~res : res;
  wire wrap = cnt >= arr_act;
  wire fire = (mode_q == FROZEN) | (res != res_q) | (hold_q & (cnt == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      arr_act <= '0;
      cmp_act <= '0;
    end else if (run) begin
      if (wrap) begin
        cnt     <= '0;
        arr_act <= arr_in;
        cmp_act <= cmp_in;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      hold_q <= 1'b0;
      res_q  <= 1'b0;
      mode_q <= FROZEN;
    end else if (run) begin
      res_q  <= res;
      mode_q <= mode;
      if (pwm && ext_clr) begin
        ref_q  <= 1'b0;
        hold_q <= 1'b1;
      end else if (pwm && fire) begin
        ref_q  <= lvl;
        hold_q <= 1'b0;
      end
    end
  end

  assign match_pulse = run & (cnt == cmp_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           flag_q <= 1'b0;
    else if (match_pulse) flag_q <= 1'b1;
    else if (flag_clr)    flag_q <= 1'b0;
  end

  assign ref_out    = ref_q;
  assign match_flag = flag_q;

  // R1: the count never passes the working reload limit
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= arr_act);

  // R10 / R11: idle settings freeze the counter and the reference
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt) && $stable(ref_out));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (dir || align != 2'b00)) |=> $stable(ref_out));

  // R8: clear forces low next clock
  p_clear_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pwm && ext_clr) |=> !ref_out);

  // R6: non-PWM codes never move the reference
  p_frozen_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pwm) |=> $stable(ref_out));

  // R9: a match always leaves the flag set
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> match_flag);

endmodule

// File: tb/pwm_edge_channel_test.sv
module pwm_edge_channel_test;
  localparam int W = 4;

  logic clk = 0, rst_n = 0;
  logic en = 0, dir = 0, ext_clr = 0, flag_clr = 0;
  logic [1:0] align = 0;
  logic [2:0] mode = 0;
  logic [W-1:0] arr_in = 0, cmp_in = 0;
  logic ref_out, match_pulse, match_flag;

  pwm_edge_channel #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .dir(dir), .align(align), .mode(mode),
    .arr_in(arr_in), .cmp_in(cmp_in), .ext_clr(ext_clr), .flag_clr(flag_clr),
    .ref_out(ref_out), .match_pulse(match_pulse), .match_flag(match_flag));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R9";
  bit done = 0;

  int m_cnt, m_arr, m_cmp, m_res, m_ref, m_hold, m_mprev, m_flag;
  int ones;

  function automatic bit m_run();
    return en && !dir && align == 0;
  endfunction

  function automatic bit m_pulse();
    return m_run() && m_cnt == m_cmp;
  endfunction

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", t, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_arr = 0; m_cmp = 0; m_res = 0; m_ref = 0; m_hold = 0;
      m_mprev = 0; m_flag = 0;
    end else begin
      bit pw, rs, lv;
      if (m_pulse()) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (m_run()) begin
        pw = (mode == 6) || (mode == 7);
        rs = m_cnt < m_cmp;
        lv = (mode == 7) ? !rs : rs;
        if (pw && ext_clr) begin
          m_ref = 0; m_hold = 1;
        end else if (pw && (m_mprev == 0 || rs != m_res || (m_hold && m_cnt == 0))) begin
          m_ref = lv; m_hold = 0;
        end
        m_res = rs; m_mprev = mode;
        if (m_cnt >= m_arr) begin
          m_cnt = 0; m_arr = arr_in; m_cmp = cmp_in;
        end else m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk({tag, " ref_out"}, ref_out, m_ref);
      chk({tag, " match_pulse"}, match_pulse, m_pulse());
      chk({tag, " match_flag"}, match_flag, m_flag);
      if (match_pulse) ones++;
    end
    if (cycles > 5000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=<5000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    tick(2);
    rst_n = 1;
    #6;
    chk("R9 reset ref_out", ref_out, 0);
    chk("R9 reset match_flag", match_flag, 0);
    tick(1);

    tag = "R3"; arr_in = 8; cmp_in = 4; mode = 3'b110; en = 1;
    tick(30);

    tag = "R1"; ones = 0;
    tick(18);
    chk("R1 matches in two periods", ones, 2);

    tag = "R2"; cmp_in = 6; tick(3); arr_in = 5; tick(25);

    tag = "R4"; mode = 3'b111; tick(20);
    mode = 3'b110; tick(10);

    tag = "R5"; arr_in = 8; cmp_in = 0; tick(25);
    cmp_in = 12; tick(25);
    arr_in = 15; cmp_in = 15; tick(40);

    tag = "R6"; arr_in = 8; cmp_in = 3; tick(12);
    mode = 3'b000; tick(15); cmp_in = 7; tick(15);
    mode = 3'b011; tick(15);

    tag = "R7"; mode = 3'b000; tick(4); mode = 3'b110; tick(3);
    mode = 3'b000; tick(5); mode = 3'b111; tick(12);

    tag = "R8"; mode = 3'b110; cmp_in = 6; tick(12);
    ext_clr = 1; tick(1); ext_clr = 0; tick(20);
    cmp_in = 12; tick(12);
    ext_clr = 1; tick(2); ext_clr = 0; tick(20);

    tag = "R9"; cmp_in = 4; tick(12);
    flag_clr = 1; tick(1); flag_clr = 0; tick(5);
    flag_clr = 1; tick(20); flag_clr = 0; tick(5);

    tag = "R10"; en = 0; tick(10); ext_clr = 1; tick(2); ext_clr = 0; en = 1; tick(10);

    tag = "R11"; dir = 1; tick(10); dir = 0; tick(5);
    align = 2'b01; tick(10); align = 2'b11; tick(5); align = 2'b00; tick(15);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule